// File: doc/BRIEF.md
# Supply Threshold Event Detector

This block turns a one-bit "supply is below threshold" indication into a status bit, two pending flags, a level interrupt and an event pulse. The indication arrives from an analog comparator and can change at any moment. A synchronizer brings it into the clock domain first. Edges of the synchronized value are then qualified by a 4-bit mode mask and by a global enable.

Software configures the block with a single write strobe. That write loads the enable, the reduced-power request, the 3-bit threshold select that goes out to the comparator, and the whole mode mask. The rising and falling pending flags are cleared by writing ones into a 2-bit clear mask. The block has no streaming data path. Every pin is a plain control or status wire with no handshake and no back-pressure.

Top module: `supply_thresh_evt`

## Requirements
- R1: `below_o` equals the value of `cmp_below_i` sampled two clock edges earlier. A change applied before edge k appears on `below_o` after edge k+1, and this holds whether or not detection is enabled.
- R2: On a `cfg_we` cycle, `level_o` and `lp_o` take `cfg_level` and `cfg_lp` at the next edge. They stay unchanged without a write. `level_o` codes 0 to 6 select the seven fixed thresholds, from the lowest to the highest. Code 7 selects the external analog input, which is compared against the internal reference.
- R3: A configuration write replaces the whole mode mask. A mode bit that is 0 in `cfg_mode` is cleared, whatever its previous value. The mask bits are: bit 0 = rising trigger, bit 1 = falling trigger, bit 2 = interrupt, bit 3 = event.
- R4: When the enable is set and mode bit 0 is set, a 0-to-1 transition of `below_o` sets `pend_rise_o` one edge after `below_o` changes.
- R5: When the enable is set and mode bit 1 is set, a 1-to-0 transition of `below_o` sets `pend_fall_o` with the same timing as R4.
- R6: A `clr_we` cycle clears the pending flags whose `clr_mask` bits are 1. Bit 0 clears the rising flag and bit 1 clears the falling flag. A flag whose mask bit is 0 is left unchanged.
- R7: If a qualifying edge and a clear of the same flag happen in the same cycle, the flag ends up set.
- R8: `irq_o` is high exactly while mode bit 2 is set and at least one pending flag is set.
- R9: When mode bit 3 and the enable are set, `evt_o` is high for exactly one cycle for each qualifying edge. That cycle is the one in which the matching pending flag becomes set.
- R10: While the enable is clear, transitions of `below_o` set no pending flag and produce no `evt_o` pulse.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_below_i | input | 1 | Asynchronous comparator result; 1 means the supply is below the threshold |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Detection enable to load |
| cfg_lp | input | 1 | Reduced-power detection request to load |
| cfg_level | input | LEVEL_W | Threshold select to load |
| cfg_mode | input | 4 | Mode mask to load (rise, fall, irq, evt from bit 0 upward) |
| clr_we | input | 1 | Pending-flag clear strobe |
| clr_mask | input | 2 | Flags to clear: bit 0 rising, bit 1 falling |
| level_o | output | LEVEL_W | Threshold select sent to the comparator |
| lp_o | output | 1 | Reduced-power request sent to the comparator |
| below_o | output | 1 | Synchronized supply-below status |
| pend_rise_o | output | 1 | Rising-edge pending flag |
| pend_fall_o | output | 1 | Falling-edge pending flag |
| irq_o | output | 1 | Level interrupt |
| evt_o | output | 1 | One-cycle event pulse |

## Verification
The bench times a clear so that it lands in the same cycle as a rising edge. A design where the clear wins would lose that edge and show the flag low. It rewrites the mode mask without the rising bit and then raises the indication. A design that merges mode bits instead of replacing them would still latch the rising flag. Other tests toggle the comparator while detection is off, and a design that gates only the interrupt would still pulse `evt_o` or set flags there. A clear of one flag while both are pending shows any design that clears both. A behavioural model compares every output on every cycle through a long pseudo-random run.

// File: rtl/ste_pkg.sv
package ste_pkg;
  localparam int MODE_W = 4;
  localparam int DIRS   = 2;

  // bit 3: event, bit 2: interrupt, bit 1: falling, bit 0: rising
  typedef struct packed {
    logic evt;
    logic irq;
    logic fall;
    logic rise;
  } mode_t;
endpackage

// File: rtl/ste_sync.sv
module ste_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ste_edge.sv
module ste_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev;

  // previous value tracks even while disabled so enabling never fakes an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl_i;
  end

  assign rise_o = en_i &  lvl_i & ~prev;
  assign fall_o = en_i & ~lvl_i &  prev;
endmodule

// File: rtl/ste_pend_flag.sv
module ste_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/supply_thresh_evt.sv
module supply_thresh_evt
  import ste_pkg::*;
#(
  parameter int LEVEL_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_below_i,
  input  logic               cfg_we,
  input  logic               cfg_en,
  input  logic               cfg_lp,
  input  logic [LEVEL_W-1:0] cfg_level,
  input  logic [MODE_W-1:0]  cfg_mode,
  input  logic               clr_we,
  input  logic [DIRS-1:0]    clr_mask,
  output logic [LEVEL_W-1:0] level_o,
  output logic               lp_o,
  output logic               below_o,
  output logic               pend_rise_o,
  output logic               pend_fall_o,
  output logic               irq_o,
  output logic               evt_o
);
  logic               en_q;
  logic               lp_q;
  logic [LEVEL_W-1:0] level_q;
  mode_t              mode_q;
  logic               evt_q;

  // whole-register load: unset mode bits are cleared
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lp_q    <= 1'b0;
      level_q <= '0;
      mode_q  <= '0;
    end else if (cfg_we) begin
      en_q    <= cfg_en;
      lp_q    <= cfg_lp;
      level_q <= cfg_level;
      mode_q  <= mode_t'(cfg_mode);
    end
  end

  logic stat;
  ste_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cmp_below_i),
    .q    (stat)
  );

  logic edge_r, edge_f;
  ste_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_q),
    .lvl_i (stat),
    .rise_o(edge_r),
    .fall_o(edge_f)
  );

  logic [DIRS-1:0] edge_v, trig_v, pend_v;
  assign edge_v = {edge_f, edge_r};
  assign trig_v = {mode_q.fall, mode_q.rise};

  for (genvar g = 0; g < DIRS; g++) begin : g_pend
    ste_pend_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (edge_v[g] & trig_v[g]),
      .clr_i (clr_we & clr_mask[g]),
      .flag_o(pend_v[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= mode_q.evt & |(edge_v & trig_v);
  end

  assign level_o     = level_q;
  assign lp_o        = lp_q;
  assign below_o     = stat;
  assign pend_rise_o = pend_v[0];
  assign pend_fall_o = pend_v[1];
  assign irq_o       = mode_q.irq & |pend_v;
  assign evt_o       = evt_q;
endmodule

// File: rtl/supply_thresh_evt_chk.sv
module supply_thresh_evt_chk #(
  parameter int LEVEL_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic               clr_we,
  input logic [1:0]         clr_mask,
  input logic               en_q,
  input logic [3:0]         mode_q,
  input logic [LEVEL_W-1:0] level_o,
  input logic               below_o,
  input logic               pend_rise_o,
  input logic               pend_fall_o,
  input logic               irq_o,
  input logic               evt_o
);
  // R4
  rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_rise_o) |-> $past(en_q && mode_q[0]) && $past(below_o) && !$past(below_o, 2));

  // R5
  fall_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_fall_o) |-> $past(en_q && mode_q[1]) && !$past(below_o) && $past(below_o, 2));

  // R6
  rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rise_o && !(clr_we && clr_mask[0])) |=> pend_rise_o);

  // R6
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_fall_o && !(clr_we && clr_mask[1])) |=> pend_fall_o);

  // R8
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_rise_o || pend_fall_o));

  // R9
  evt_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(en_q && mode_q[3]));

  // R10
  no_evt_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !evt_o);

  // R2
  level_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(level_o));
endmodule

bind supply_thresh_evt supply_thresh_evt_chk #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .clr_we     (clr_we),
  .clr_mask   (clr_mask),
  .en_q       (en_q),
  .mode_q     (mode_q),
  .level_o    (level_o),
  .below_o    (below_o),
  .pend_rise_o(pend_rise_o),
  .pend_fall_o(pend_fall_o),
  .irq_o      (irq_o),
  .evt_o      (evt_o)
);

// File: tb/supply_thresh_evt_bench.sv
module supply_thresh_evt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_below_i = 1'b0;
  logic       cfg_we = 1'b0, cfg_en = 1'b0, cfg_lp = 1'b0;
  logic [2:0] cfg_level = '0;
  logic [3:0] cfg_mode = '0;
  logic       clr_we = 1'b0;
  logic [1:0] clr_mask = '0;
  logic [2:0] level_o;
  logic       lp_o, below_o, pend_rise_o, pend_fall_o, irq_o, evt_o;

  int n_chk = 0, n_fail = 0;
  bit compare_on = 0;

  always #10 clk = ~clk;

  supply_thresh_evt u_supply_thresh_evt (
    .clk(clk), .rst_n(rst_n), .cmp_below_i(cmp_below_i),
    .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_lp(cfg_lp),
    .cfg_level(cfg_level), .cfg_mode(cfg_mode),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .level_o(level_o), .lp_o(lp_o), .below_o(below_o),
    .pend_rise_o(pend_rise_o), .pend_fall_o(pend_fall_o),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit   m_in_q[$];
  bit   m_stat, m_stat_d, m_en, m_lp, m_pr, m_pf, m_evt;
  int   m_level;
  bit [3:0] m_mode;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_in_q = {}; m_stat = 0; m_stat_d = 0; m_en = 0; m_lp = 0;
      m_pr = 0; m_pf = 0; m_evt = 0; m_level = 0; m_mode = 0;
    end else begin
      bit up, down;
      up   = m_en && m_mode[0] && m_stat && !m_stat_d;
      down = m_en && m_mode[1] && !m_stat && m_stat_d;
      m_pr = up   || (m_pr && !(clr_we && clr_mask[0]));
      m_pf = down || (m_pf && !(clr_we && clr_mask[1]));
      m_evt = m_en && m_mode[3] && (up || down);
      m_stat_d = m_stat;
      m_in_q.push_back(cmp_below_i);
      m_stat = (m_in_q.size() >= 2) ? m_in_q[m_in_q.size()-2] : 1'b0;
      if (m_in_q.size() > 4) void'(m_in_q.pop_front());
      if (cfg_we) begin
        m_en = cfg_en; m_lp = cfg_lp; m_level = cfg_level; m_mode = cfg_mode;
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      chk("R1 below_o", below_o, m_stat);
      chk("R2 level_o", level_o, m_level);
      chk("R2 lp_o", lp_o, m_lp);
      chk("R4 pend_rise_o", pend_rise_o, m_pr);
      chk("R5 pend_fall_o", pend_fall_o, m_pf);
      chk("R8 irq_o", irq_o, m_mode[2] && (m_pr || m_pf));
      chk("R9 evt_o", evt_o, m_evt);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input bit en, input bit lp, input int lvl, input int mode);
    cfg_we = 1; cfg_en = en; cfg_lp = lp; cfg_level = 3'(lvl); cfg_mode = 4'(mode);
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic clr(input int mask);
    clr_we = 1; clr_mask = 2'(mask);
    cyc(1);
    clr_we = 0; clr_mask = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int evt_cnt;
    int lfsr;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R11 reset state
    chk("R11 level_o", level_o, 0);
    chk("R11 pend_rise_o", pend_rise_o, 0);
    chk("R11 pend_fall_o", pend_fall_o, 0);
    chk("R11 irq_o", irq_o, 0);
    chk("R11 evt_o", evt_o, 0);
    chk("R11 below_o", below_o, 0);
    compare_on = 1;

    // R2 level pass-through, R4 rising with irq (mode 0x05)
    cfg(1, 1, 3, 4'h5);
    chk("R2 level_o", level_o, 3);
    chk("R2 lp_o", lp_o, 1);
    cmp_below_i = 1;
    cyc(2);
    chk("R1 below_o after two edges", below_o, 1);
    chk("R4 pend_rise_o not yet", pend_rise_o, 0);
    cyc(1);
    chk("R4 pend_rise_o set", pend_rise_o, 1);
    chk("R8 irq_o set", irq_o, 1);

    // R5 falling not armed: no fall flag
    cmp_below_i = 0;
    cyc(4);
    chk("R5 pend_fall_o unarmed", pend_fall_o, 0);

    // R3 rewrite mode without rise bit (fall|evt)
    cfg(1, 0, 7, 4'hA);
    chk("R2 level_o external code", level_o, 7);
    chk("R8 irq_o off with mode bit2 clear", irq_o, 0);
    clr(1);
    chk("R6 pend_rise_o cleared", pend_rise_o, 0);
    cmp_below_i = 1;
    cyc(5);
    chk("R3 rise bit replaced, no flag", pend_rise_o, 0);
    cmp_below_i = 0;
    evt_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      if (evt_o) evt_cnt++;
    end
    chk("R5 pend_fall_o set", pend_fall_o, 1);
    chk("R9 one event pulse", evt_cnt, 1);

    // R6 clear only one of two pending flags
    cfg(1, 0, 2, 4'h7);
    cmp_below_i = 1;
    cyc(5);
    chk("R6 both pending rise", pend_rise_o, 1);
    clr(1);
    chk("R6 rise cleared", pend_rise_o, 0);
    chk("R6 fall kept", pend_fall_o, 1);
    clr(2);
    chk("R6 fall cleared", pend_fall_o, 0);

    // R7 clear in the edge cycle
    cmp_below_i = 0;
    cyc(5);
    clr(3);
    cmp_below_i = 1;
    cyc(2);
    clr_we = 1; clr_mask = 2'b01;
    cyc(1);
    clr_we = 0; clr_mask = 0;
    chk("R7 set wins over clear", pend_rise_o, 1);
    clr(3);

    // R10 disabled: status tracks, nothing latches
    cfg(0, 0, 1, 4'hF);
    evt_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      cmp_below_i = ~cmp_below_i;
      for (int j = 0; j < 4; j++) begin
        cyc(1);
        if (evt_o) evt_cnt++;
      end
    end
    chk("R10 no events while disabled", evt_cnt, 0);
    chk("R10 no rise flag while disabled", pend_rise_o, 0);
    chk("R10 no fall flag while disabled", pend_fall_o, 0);
    chk("R1 status tracks while disabled", below_o, cmp_below_i);

    // pseudo-random run against the model
    lfsr = 32'h1ace;
    for (int i = 0; i < 3000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      cmp_below_i = (lfsr[3:0] < 5) ? ~cmp_below_i : cmp_below_i;
      cfg_we   = (lfsr[9:4] == 0);
      cfg_en   = lfsr[10] | lfsr[11];
      cfg_lp   = lfsr[12];
      cfg_level = lfsr[15:13];
      cfg_mode = lfsr[7:4];
      clr_we   = (lfsr[14:11] == 3);
      clr_mask = lfsr[1:0];
      cyc(1);
    end
    cfg_we = 0; clr_we = 0;
    cyc(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule